// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block compares the rising edges of a reference clock with the rising edges of a divided feedback clock and produces the pump-up and pump-down pulses that drive a charge pump. Both clock inputs are asynchronous. Each is brought into the domain of a fast measurement clock `clk` through a two-flop synchronizer, followed by a rising-edge detector. All decisions are made in that domain. The detector is the usual three-state machine: idle, pumping up, or pumping down.

Each closed edge pair is one comparison. Its phase error is the time the up or down pulse was active, counted in `clk` cycles. A comparison passes when that width does not exceed `ERR_MAX`. The `locked` flag rises after 3 or 5 consecutive passing comparisons, selected by `sel_five`. A single failing comparison drops it at once. A separate output, `lock_raw`, is the complement of up XOR down. It rests high and carries narrow low pulses while the loop is tracking, and it can be filtered outside the block.

If the reference clock stops, no further comparisons complete. A lock decision made only at comparisons would then keep a stale high flag. To prevent this, a watchdog counts `clk` cycles since the last reference edge. At the timeout it raises `ref_lost`, forces `locked` low and clears the pass count.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `up`, `dn`, `locked` and `ref_lost` are 0 and `lock_raw` is 1.
- R2: A synchronized reference rising edge sets `up` and a synchronized feedback rising edge sets `dn`. When the second edge of a pair arrives, both clear together. `up` and `dn` are never high in the same cycle. A lead of d cycles between the two inputs gives a pulse exactly d cycles wide on the leading side and none on the other.
- R3: `lock_raw` equals NOT(`up` XOR `dn`). It is low for exactly as many cycles as the error pulse lasts.
- R4: A comparison passes when its pulse width is at most `ERR_MAX` cycles (default 3). The width is 3 for a lead of 3 and fails for a lead of 4. `locked` is high once the consecutive pass count reaches 3 when `sel_five` is 0, or 5 when `sel_five` is 1.
- R5: A failing comparison clears the pass count and drives `locked` low from the next cycle on.
- R6: Edges of both inputs seen in the same sample cycle close a comparison of width 0, which passes.
- R7: When `REF_TIMEOUT` cycles (default 64) pass without a reference rising edge, `ref_lost` goes high, `locked` goes low and the pass count is cleared. The next reference edge clears `ref_lost`, and lock must then be rebuilt from zero.
- R8: A second reference edge while `up` is already high does not end the pulse. `up` stays high until a feedback edge arrives, and that comparison fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| sel_five | input | 1 | 1: lock needs 5 passes, 0: lock needs 3 |
| up | output | 1 | Pump-up pulse |
| dn | output | 1 | Pump-down pulse |
| lock_raw | output | 1 | NOT(up XOR down) raw lock pulse train |
| locked | output | 1 | Digital lock flag |
| ref_lost | output | 1 | Reference absent for the timeout |

## Verification
A wrong detector state appears on `up`, `dn` and `lock_raw` within a few cycles of the next edge. It shows as a pulse of the wrong width, a pulse on the wrong side, or a pulse that never ends. A wrong pass count or width comparison shows only at the end of a comparison, when `locked` rises one comparison early or late, or fails to fall after an over-limit error. A stuck watchdog shows on `ref_lost` and `locked` only after the full timeout has passed with the reference idle. The stimulus therefore walks lead values on both sides of the limit, under both lock-count settings, and includes a long reference gap.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Detector state: idle, pumping up, pumping down
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10
    } pfd_state_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_pulse_t;

    localparam int unsigned LOCK_SHORT = 3;
    localparam int unsigned LOCK_LONG  = 5;
    localparam int unsigned PASS_W     = 3;

    function automatic pfd_state_t pfd_next(input pfd_state_t s, input logic r, input logic f);
        pfd_state_t n;
        case (s)
            PFD_IDLE: n = (r && f) ? PFD_IDLE : (r ? PFD_UP : (f ? PFD_DN : PFD_IDLE));
            PFD_UP:   n = f ? PFD_IDLE : PFD_UP;
            PFD_DN:   n = r ? PFD_IDLE : PFD_DN;
            default:  n = PFD_IDLE;
        endcase
        return n;
    endfunction

    // True when this cycle closes an edge pair
    function automatic logic pair_closes(input pfd_state_t s, input logic r, input logic f);
        return (s == PFD_IDLE && r && f) || (s == PFD_UP && f) || (s == PFD_DN && r);
    endfunction

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // two synchronizer flops then one history flop for edge detection
    logic [2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[1:0], async_in};
    end

    assign rise = shreg[1] & ~shreg[2];
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             fb_rise,
    output pfd_pulse_t       pulse,
    output logic             cmp_done,
    output logic [ERR_W-1:0] cmp_width
);
    localparam logic [ERR_W-1:0] WMAX = '1;

    pfd_state_t       state;
    logic [ERR_W-1:0] err_cnt;
    logic             active;

    assign active    = (state != PFD_IDLE);
    assign cmp_done  = pair_closes(state, ref_rise, fb_rise);
    assign cmp_width = (err_cnt == WMAX) ? WMAX : err_cnt + ERR_W'(active);
    assign pulse.up  = (state == PFD_UP);
    assign pulse.dn  = (state == PFD_DN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PFD_IDLE;
            err_cnt <= '0;
        end else begin
            state <= pfd_next(state, ref_rise, fb_rise);
            if (cmp_done)                      err_cnt <= '0;
            else if (active && err_cnt != WMAX) err_cnt <= err_cnt + 1'b1;
        end
    end

    assert_up_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse.up) |-> $past(ref_rise));
    assert_dn_src_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse.dn) |-> $past(fb_rise));
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(pulse.up && pulse.dn));
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
    import pfd_pkg::*;
#(
    parameter int unsigned ERR_W       = 3,
    parameter int unsigned ERR_MAX     = 3,
    parameter int unsigned REF_TIMEOUT = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_five,
    input  logic             ref_rise,
    input  logic             cmp_done,
    input  logic [ERR_W-1:0] cmp_width,
    output logic             locked,
    output logic             ref_lost
);
    localparam int unsigned      WD_W    = $clog2(REF_TIMEOUT + 1);
    localparam logic [WD_W-1:0]  WD_LAST = WD_W'(REF_TIMEOUT - 1);
    localparam logic [PASS_W-1:0] P_SHORT = PASS_W'(LOCK_SHORT);
    localparam logic [PASS_W-1:0] P_LONG  = PASS_W'(LOCK_LONG);

    logic [WD_W-1:0]   wd_cnt;
    logic [PASS_W-1:0] pass_cnt;
    logic              pass, wd_fire;

    assign pass    = (cmp_width <= ERR_W'(ERR_MAX));
    assign wd_fire = !ref_rise && (wd_cnt == WD_LAST);
    assign locked  = (pass_cnt >= (sel_five ? P_LONG : P_SHORT)) && !ref_lost;

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_cnt   <= '0;
            ref_lost <= 1'b0;
            pass_cnt <= '0;
        end else begin
            if (ref_rise) begin
                wd_cnt   <= '0;
                ref_lost <= 1'b0;
            end else if (wd_fire) begin
                ref_lost <= 1'b1;
            end else begin
                wd_cnt <= wd_cnt + 1'b1;
            end

            if (wd_fire || (ref_lost && !ref_rise))
                pass_cnt <= '0;
            else if (cmp_done)
                pass_cnt <= !pass ? '0 : ((pass_cnt >= P_LONG) ? P_LONG : pass_cnt + 1'b1);
        end
    end

    assert_fail_unlocks_R5: assert property (@(posedge clk) disable iff (rst)
        (cmp_done && cmp_width > ERR_W'(ERR_MAX)) |=> !locked);
    assert_lost_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        ref_lost |-> !locked);
    assert_lost_needs_gap_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_lost) |-> $past(!ref_rise));
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned ERR_MAX     = 3,
    parameter int unsigned REF_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    input  logic sel_five,
    output logic up,
    output logic dn,
    output logic lock_raw,
    output logic locked,
    output logic ref_lost
);
    localparam int unsigned ERR_W = $clog2(ERR_MAX + 2);

    logic [1:0]       raw_in;
    logic [1:0]       rise;
    pfd_pulse_t       pulse;
    logic             cmp_done;
    logic [ERR_W-1:0] cmp_width;

    assign raw_in = {fb_in, ref_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        pfd_sync_edge u_sync (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_in[g]),
            .rise     (rise[g])
        );
    end

    pfd_core #(.ERR_W(ERR_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ref_rise  (rise[0]),
        .fb_rise   (rise[1]),
        .pulse     (pulse),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width)
    );

    pfd_lock_mon #(.ERR_W(ERR_W), .ERR_MAX(ERR_MAX), .REF_TIMEOUT(REF_TIMEOUT)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .sel_five  (sel_five),
        .ref_rise  (rise[0]),
        .cmp_done  (cmp_done),
        .cmp_width (cmp_width),
        .locked    (locked),
        .ref_lost  (ref_lost)
    );

    assign up       = pulse.up;
    assign dn       = pulse.dn;
    assign lock_raw = ~(pulse.up ^ pulse.dn);

    assert_raw_tracks_R3: assert property (@(posedge clk) disable iff (rst)
        (up || dn) |-> !lock_raw);
endmodule

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic sel;
        int   d;
        int   n;
        logic exp;
    } vec_t;

    // lead d (>0 reference first), pairs n, expected locked afterwards
    localparam vec_t VEC [9] = '{
        '{1'b0,  0, 3, 1'b1},   // R4 R6: three zero-width passes lock
        '{1'b0,  4, 1, 1'b0},   // R5: width 4 fails
        '{1'b0,  3, 2, 1'b0},   // R4: boundary passes, only two so far
        '{1'b0, -3, 1, 1'b1},   // R4: third pass, feedback leading
        '{1'b1,  1, 1, 1'b0},   // R4: four passes, five required
        '{1'b1, -2, 1, 1'b1},   // R4: fifth pass
        '{1'b1, -5, 1, 1'b0},   // R5
        '{1'b1,  2, 4, 1'b0},   // R4
        '{1'b1,  0, 1, 1'b1}    // R4 R6
    };

    logic clk = 0, rst = 1, ref_in = 0, fb_in = 0, sel_five = 0;
    logic up, dn, lock_raw, locked, ref_lost;
    int n_cmp = 0, n_bad = 0;
    int up_hi, dn_hi, raw_lo;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_top u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .sel_five(sel_five),
        .up(up), .dn(dn), .lock_raw(lock_raw), .locked(locked), .ref_lost(ref_lost)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic f, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            up_hi  += int'(up);
            dn_hi  += int'(dn);
            raw_lo += int'(!lock_raw);
            ref_in = r;
            fb_in  = f;
        end
    endtask

    task automatic run_pair(input int d);
        int a;
        a = (d < 0) ? -d : d;
        up_hi = 0; dn_hi = 0; raw_lo = 0;
        if (d >= 0) begin
            drive(1, 0, a); drive(1, 1, 6 - a); drive(0, 1, a);
        end else begin
            drive(0, 1, a); drive(1, 1, 6 - a); drive(1, 0, a);
        end
        drive(0, 0, 6);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 up", up, 0);
        check("R1 dn", dn, 0);
        check("R1 locked", locked, 0);
        check("R1 lock_raw", lock_raw, 1);
        @(negedge clk) rst = 0;
        @(negedge clk);
        check("R1 ref_lost", ref_lost, 0);
        check("R1 locked after release", locked, 0);

        foreach (VEC[i]) begin
            sel_five = VEC[i].sel;
            for (int k = 0; k < VEC[i].n; k++) run_pair(VEC[i].d);
            check($sformatf("R4/R5 vector %0d locked", i), locked, VEC[i].exp);
        end

        // R2 R3: pulse widths and raw train
        run_pair(3);
        check("R2 up width lead 3", up_hi, 3);
        check("R2 dn silent", dn_hi, 0);
        check("R3 raw low width", raw_lo, 3);
        run_pair(-2);
        check("R2 dn width lead 2", dn_hi, 2);
        check("R2 up silent", up_hi, 0);
        check("R3 raw low width fb", raw_lo, 2);
        check("R4 still locked", locked, 1);

        // R7: reference loss
        sel_five = 0;
        drive(0, 0, 40);
        check("R7 no loss before timeout", ref_lost, 0);
        check("R7 lock held before timeout", locked, 1);
        drive(0, 0, 40);
        check("R7 loss flagged", ref_lost, 1);
        check("R7 lock cleared", locked, 0);
        run_pair(0);
        check("R7 loss cleared", ref_lost, 0);
        check("R7 count restarted", locked, 0);
        run_pair(1); run_pair(-1);
        check("R7 relock after three", locked, 1);

        // R8: repeated reference edge without feedback
        up_hi = 0;
        drive(1, 0, 6); drive(0, 0, 6); drive(1, 0, 6); drive(0, 0, 3);
        check("R8 up held", up, 1);
        check("R8 up long", int'(up_hi >= 15), 1);
        drive(0, 1, 6); drive(0, 0, 6);
        check("R8 up ended", up, 0);
        check("R8 lock dropped", locked, 0);

        done = 1;
        summary();
    end
endmodule